// File: doc/BRIEF.md
# SRAM Cache Burst Sequencer

This block drives line reads from an asynchronous SRAM second-level cache onto a 32-bit host bus. A line is 16 bytes, so it moves as four 32-bit words. A one-cycle start strobe carries a line address and a two-bit timing select. From these the sequencer produces the SRAM word address, an active-low output enable, a ready strobe for each word, a busy indication and a one-cycle done flag.

The timing select picks how many bus cycles each beat lasts. The first word takes the lead-off length and each of the three later words takes the burst length. This gives the patterns 2-1-1-1, 3-1-1-1, 2-2-2-2 and 3-2-2-2. Ready rises only in the closing cycle of a beat, so the SRAM data has the whole beat to settle before the host takes it. Tag lookup, writes and any fallback to main memory are handled elsewhere.

Top module: `l2b_burst_seq`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released with no start, `busy_o`, `rdy_o` and `done_o` are 0 and `sram_oe_n_o` is 1.
- R2: `tsel_i` encoding: 0 gives 2-1-1-1, 1 gives 3-1-1-1, 2 gives 2-2-2-2 and 3 gives 3-2-2-2. Word 0 lasts the first number of cycles and each later word lasts the second. `rdy_o` is 1 only in the last cycle of each beat.
- R3: From the first busy cycle to the fourth ready strobe, a burst takes 5, 6, 8 or 9 cycles for select values 0, 1, 2 or 3.
- R4: While busy, `sram_addr_o` equals line address bits [ADDR_W-1:4] followed by the word index in bits [3:2] and zeros in bits [1:0]. Words are issued in the order 0, 1, 2, 3, and bits [3:0] of the start address are ignored.
- R5: The word index changes only in the cycle that follows a ready strobe.
- R6: `sram_oe_n_o` is 0 exactly in the cycles where `busy_o` is 1.
- R7: `tsel_i` is captured when a start is accepted. Changing it during a burst does not alter that burst's timing.
- R8: A start strobe seen while `busy_o` is 1 is ignored. The running burst keeps its address, its timing and its length.
- R9: `done_o` is 1 for exactly one cycle, the cycle right after the fourth ready strobe, and `busy_o` is 0 in that cycle. A start in the done cycle is accepted.
- R10: A start sampled while `busy_o` is 0 makes `busy_o` 1 in the next cycle, with word 0 on the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst request strobe |
| line_addr_i | input | ADDR_W | Line address; low line-offset bits are ignored |
| tsel_i | input | 2 | Timing pattern select |
| sram_addr_o | output | ADDR_W | SRAM word address |
| sram_oe_n_o | output | 1 | SRAM output enable, active low |
| rdy_o | output | 1 | Word ready strobe to the host |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle line-complete pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 32-bit words and four words per line. With these, all four timing patterns and the full 16-byte line stepping can be exercised. Start addresses with non-zero low nibbles and high upper bits show that only the tag part is carried through. Deliberate start and select noise during bursts, plus a start placed exactly in the done cycle, reach the boundaries between consecutive bursts.

// File: rtl/l2b_pkg.sv
package l2b_pkg;

  typedef enum logic [1:0] {
    PAT_L2_B1 = 2'd0,
    PAT_L3_B1 = 2'd1,
    PAT_L2_B2 = 2'd2,
    PAT_L3_B2 = 2'd3
  } pat_e;

  localparam int unsigned LEN_W = 2;

  function automatic logic [LEN_W-1:0] lead_len(input pat_e p);
    case (p)
      PAT_L3_B1, PAT_L3_B2: lead_len = 2'd3;
      default:              lead_len = 2'd2;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] beat_len(input pat_e p);
    case (p)
      PAT_L2_B2, PAT_L3_B2: beat_len = 2'd2;
      default:              beat_len = 2'd1;
    endcase
  endfunction

  function automatic int unsigned line_cycles(input pat_e p, input int unsigned words);
    line_cycles = int'(lead_len(p)) + (words - 1) * int'(beat_len(p));
  endfunction

endpackage

// File: rtl/l2b_beat_timer.sv
module l2b_beat_timer #(
  parameter int unsigned LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             run_i,
  output logic             expire_o
);

  logic [LEN_W-1:0] cnt_q;

  // Holds cycles remaining in the current beat, minus one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i - LEN_W'(1);
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - LEN_W'(1);
    end
  end

  assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/l2b_word_ctr.sv
module l2b_word_ctr #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned WORD_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              adv_i,
  output logic [WORD_W-1:0] word_o,
  output logic              last_o
);

  localparam logic [WORD_W-1:0] LAST_IDX = WORD_W'(WORDS - 1);

  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (clear_i) begin
      word_q <= '0;
    end else if (adv_i) begin
      word_q <= word_q + WORD_W'(1);
    end
  end

  assign word_o = word_q;
  assign last_o = (word_q == LAST_IDX);

endmodule

// File: rtl/l2b_burst_seq.sv
module l2b_burst_seq #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] line_addr_i,
  input  logic [1:0]        tsel_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_oe_n_o,
  output logic              rdy_o,
  output logic              busy_o,
  output logic              done_o
);
  import l2b_pkg::*;

  localparam int unsigned OFF_W  = $clog2(DATA_W / 8);
  localparam int unsigned WORD_W = $clog2(WORDS);
  localparam int unsigned LINE_W = OFF_W + WORD_W;
  localparam int unsigned TAG_W  = ADDR_W - LINE_W;

  logic              busy_q;
  logic              done_q;
  pat_e              tsel_q;
  logic [TAG_W-1:0]  base_q;

  // Named internal events
  logic              start_acc;
  logic              beat_end;
  logic              line_end;
  logic              beat_expire;
  logic              word_last;
  logic [WORD_W-1:0] word_idx;
  logic              tmr_load;
  logic [LEN_W-1:0]  tmr_len;

  assign start_acc = start_i & ~busy_q;
  assign beat_end  = busy_q & beat_expire;
  assign line_end  = beat_end & word_last;
  assign tmr_load  = start_acc | (beat_end & ~word_last);
  assign tmr_len   = start_acc ? lead_len(pat_e'(tsel_i)) : beat_len(tsel_q);

  l2b_beat_timer #(
    .LEN_W(LEN_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .len_i    (tmr_len),
    .run_i    (busy_q),
    .expire_o (beat_expire)
  );

  l2b_word_ctr #(
    .WORDS  (WORDS),
    .WORD_W (WORD_W)
  ) u_words (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_acc),
    .adv_i   (beat_end & ~word_last),
    .word_o  (word_idx),
    .last_o  (word_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      tsel_q <= PAT_L2_B1;
      base_q <= '0;
    end else begin
      done_q <= line_end;
      if (start_acc) begin
        busy_q <= 1'b1;
        tsel_q <= pat_e'(tsel_i);
        base_q <= line_addr_i[ADDR_W-1:LINE_W];
      end else if (line_end) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign sram_addr_o = {base_q, word_idx, {OFF_W{1'b0}}};
  assign sram_oe_n_o = ~busy_q;
  assign rdy_o       = beat_end;
  assign busy_o      = busy_q;
  assign done_o      = done_q;

endmodule

// File: rtl/l2b_burst_seq_chk.sv
module l2b_burst_seq_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 2,
  parameter int unsigned LINE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_oe_n_o,
  input logic              rdy_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        tsel_q
);
  localparam int unsigned WORD_W = LINE_W - OFF_W;

  // R2: ready only inside an active read, never in a burst's first cycle
  p_rdy_in_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> (busy_o && !sram_oe_n_o));
  p_lead_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !rdy_o);

  // R4: byte-offset bits stay clear while reading
  p_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (sram_addr_o[OFF_W-1:0] == '0));

  // R5: address holds until ready, then steps by one word
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !rdy_o) |=> $stable(sram_addr_o));
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && rdy_o) |=> (done_o ||
      sram_addr_o[LINE_W-1:OFF_W] == $past(sram_addr_o[LINE_W-1:OFF_W]) + WORD_W'(1)));

  // R7 / R8: captured select and the burst survive start noise
  p_tsel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !rdy_o) |=> $stable(tsel_q));
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !rdy_o) |=> (busy_o && !done_o));

  // R9: single-cycle done right after the last ready
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_after_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(rdy_o)));

  // R10: an idle start launches a burst next cycle
  p_start_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

endmodule

bind l2b_burst_seq l2b_burst_seq_chk #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W),
  .LINE_W (LINE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .sram_addr_o (sram_addr_o),
  .sram_oe_n_o (sram_oe_n_o),
  .rdy_o       (rdy_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .tsel_q      (tsel_q)
);

// File: tb/l2b_burst_seq_tb.sv
module l2b_burst_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] line_addr_i = '0;
  logic [1:0]  tsel_i = '0;
  logic [31:0] sram_addr_o;
  logic        sram_oe_n_o, rdy_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2b_burst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_addr_i(line_addr_i),
    .tsel_i(tsel_i), .sram_addr_o(sram_addr_o), .sram_oe_n_o(sram_oe_n_o),
    .rdy_o(rdy_o), .busy_o(busy_o), .done_o(done_o)
  );

  // Reference timing, written from the requirement text
  function automatic int first_len(input logic [1:0] s);
    return (s == 2'd1 || s == 2'd3) ? 3 : 2;
  endfunction
  function automatic int later_len(input logic [1:0] s);
    return (s >= 2'd2) ? 2 : 1;
  endfunction

  typedef struct {
    bit          busy;
    bit          rdy;
    bit          done;
    logic [31:0] addr;
  } exp_t;

  exp_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
    end
  endtask

  // Reference model: queue of expected per-cycle outputs
  always @(posedge clk) begin : model
    bit was_busy;
    if (!rst_n) begin
      exp_q.delete();
    end else begin
      was_busy = 1'b0;
      if (exp_q.size() > 0) begin
        was_busy = exp_q[0].busy;
        void'(exp_q.pop_front());
      end
      if (!was_busy && start_i) begin
        for (int w = 0; w < 4; w++) begin
          int len;
          len = (w == 0) ? first_len(tsel_i) : later_len(tsel_i);
          for (int c = 1; c <= len; c++) begin
            exp_t e;
            e.busy = 1'b1;
            e.rdy  = (c == len);
            e.done = 1'b0;
            e.addr = {line_addr_i[31:4], 2'(w), 2'b00};
            exp_q.push_back(e);
          end
        end
        begin
          exp_t d;
          d.busy = 1'b0; d.rdy = 1'b0; d.done = 1'b1; d.addr = '0;
          exp_q.push_back(d);
        end
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin : compare
    exp_t e;
    if (rst_n) begin
      if (exp_q.size() > 0) e = exp_q[0];
      else begin e.busy = 0; e.rdy = 0; e.done = 0; e.addr = '0; end
      check(busy_o == e.busy, "R10", "busy_o", 32'(busy_o), 32'(e.busy));
      check(sram_oe_n_o == !e.busy, "R6", "sram_oe_n_o", 32'(sram_oe_n_o), 32'(!e.busy));
      check(rdy_o == e.rdy, "R2", "rdy_o", 32'(rdy_o), 32'(e.rdy));
      check(done_o == e.done, "R9", "done_o", 32'(done_o), 32'(e.done));
      if (e.busy)
        check(sram_addr_o == e.addr, "R4/R5", "sram_addr_o", sram_addr_o, e.addr);
    end
  end

  // One burst; noise drives start and select while busy (R7, R8)
  task automatic burst(input logic [31:0] addr, input logic [1:0] sel,
                       input bit noise, input string req);
    int n, expn, guard;
    expn = first_len(sel) + 3 * later_len(sel);
    @(negedge clk);
    start_i = 1'b1; line_addr_i = addr; tsel_i = sel;
    @(negedge clk);
    n = 0; guard = 0;
    while (!done_o && guard < 40) begin
      if (busy_o) n++;
      if (noise) begin
        start_i = 1'b1; tsel_i = ~tsel_i; line_addr_i = ~addr;
      end else begin
        start_i = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    start_i = 1'b0; tsel_i = sel; line_addr_i = addr;
    check(n == expn, req, "burst length", 32'(n), 32'(expn));
  endtask

  initial begin : stim
    // R1: reset state while held and just after release
    repeat (3) @(negedge clk);
    check(!busy_o && !rdy_o && !done_o && sram_oe_n_o, "R1", "outputs in reset",
          {28'd0, busy_o, rdy_o, done_o, sram_oe_n_o}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !rdy_o && !done_o && sram_oe_n_o, "R1", "outputs after reset",
          {28'd0, busy_o, rdy_o, done_o, sram_oe_n_o}, 32'h1);

    // R3: each pattern's length; low nibble of address ignored (R4)
    burst(32'hDEAD_BEEF, 2'd0, 1'b0, "R3");
    burst(32'h1234_5677, 2'd1, 1'b0, "R3");
    burst(32'h0000_0010, 2'd2, 1'b0, "R3");
    burst(32'hFFFF_FFFF, 2'd3, 1'b0, "R3");

    // R7 / R8: select changes and extra starts during bursts
    burst(32'hA5A5_A5A0, 2'd0, 1'b1, "R7");
    burst(32'h5A5A_5A5C, 2'd3, 1'b1, "R8");
    burst(32'h0F0F_0F00, 2'd1, 1'b1, "R8");
    burst(32'h7000_0004, 2'd2, 1'b1, "R7");

    // R9: start in the done cycle is accepted
    @(negedge clk);
    start_i = 1'b1; line_addr_i = 32'hCAFE_0000; tsel_i = 2'd3;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    start_i = 1'b1; line_addr_i = 32'hBEEF_0030; tsel_i = 2'd0;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R9", "busy after start in done cycle", 32'(busy_o), 32'd1);
    check(sram_addr_o == 32'hBEEF_0030, "R10", "first word of chained burst",
          sram_addr_o, 32'hBEEF_0030);
    while (!done_o) @(negedge clk);

    // Mixed sequence across patterns and addresses
    for (int i = 0; i < 8; i++)
      burst(32'h1000_0000 * i + 32'h44 * i, 2'(i), 1'(i), (i % 2) ? "R8" : "R3");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin : watchdog
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog actual=%0d expected=<%0d cycles", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule